// File: doc/BRIEF.md
# Checkpointed Integer Register File

This block is an integer register file that keeps a second, known-good copy of its lower registers so that the owning pipeline can checkpoint and restore architectural state in one clock. The working copy serves two combinational read ports and one synchronous write port. Only a leading subset of the registers has a backup copy. The rest are plain storage that checkpoint and restore never touch.

A pulse on `commit` marks a safe point. Every backed-up working register is copied into its backup copy on that edge. A pulse on `rollback` discards all speculative updates to the backed-up registers by loading them from the backup copy on that edge. The logic that decides when to commit or roll back (exception detection, replay, emulation) sits outside this block.

Top module: `ckpt_regfile`

## Requirements
- R1: While `rst_n` is low, every working register and every backup register is zero. A rollback issued before any commit therefore returns registers 0..47 to zero.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored in register `wr_addr`, and both read ports return it from the next cycle on. When `wr_en` is low, no register changes, whatever is on `wr_addr` and `wr_data`.
- R3: The two read ports are combinational and independent. `rdN_data` shows the working value of register `rdN_addr`. A read of a register that is being written in the same cycle returns the value it held before that edge.
- R4: A commit (`commit`=1, `rollback`=0) copies working registers 0..47 into their backup copies. Without a commit, the backup copies hold their values.
- R5: A rollback loads working registers 0..47 from their backup copies on the edge where `rollback` is high. From the next cycle on, they read back their values as of the last commit.
- R6: Registers 48..63 have no backup copy. Commit and rollback leave their working values unchanged.
- R7: When a write to a register in 0..47 coincides with a commit, the backup copy receives the newly written value, and the working register holds it too.
- R8: When `commit` and `rollback` are high together, the rollback is carried out and the commit is ignored, so the backup copies keep their earlier contents.
- R9: During a rollback, a write to a register in 0..47 is dropped. A write to a register in 48..63 takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable for the working copy |
| wr_addr | input | 6 | Register index to write |
| wr_data | input | 32 | Data to write |
| rd0_addr | input | 6 | Register index for read port 0 |
| rd0_data | output | 32 | Working value for read port 0 |
| rd1_addr | input | 6 | Register index for read port 1 |
| rd1_data | output | 32 | Working value for read port 1 |
| commit | input | 1 | Checkpoint backed-up working registers |
| rollback | input | 1 | Restore backed-up working registers |

## Verification
The bench sweeps every register through both read ports after each phase of the test. A design that restored or checkpointed the wrong span would show up at the boundary between registers 47 and 48. A design that forgot to clear the backup copy at reset would return stale data on a rollback with no prior commit.

The bench also drives the colliding cases. The first is a write landing in the same edge as a commit, where a design that snapshots the pre-write value commits stale data. The second is commit and rollback together, where a design that lets commit win overwrites the checkpoint with speculative data. The third is a write during a rollback, where a design that lets the write win leaves a speculative value in a restored register, or drops a legal write to an upper register. A same-cycle read-during-write check catches a read path that bypasses the newly written data.

// File: rtl/srf_pkg.sv
package srf_pkg;

   typedef enum logic [1:0] {
      CK_HOLD    = 2'd0,
      CK_COMMIT  = 2'd1,
      CK_RESTORE = 2'd2
   } ck_op_e;

endpackage

// File: rtl/srf_ck_arbiter.sv
module srf_ck_arbiter
   import srf_pkg::*;
(
   input  logic   commit_i,
   input  logic   rollback_i,
   output ck_op_e op_o
);

   always_comb begin
      if (rollback_i)
         op_o = CK_RESTORE;
      else if (commit_i)
         op_o = CK_COMMIT;
      else
         op_o = CK_HOLD;
   end

endmodule

// File: rtl/srf_cell_shadowed.sv
module srf_cell_shadowed
   import srf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wd_i,
   input  ck_op_e            op_i,
   output logic [DATA_W-1:0] work_o,
   output logic [DATA_W-1:0] shadow_o
);

   logic [DATA_W-1:0] work_q;
   logic [DATA_W-1:0] shadow_q;
   logic [DATA_W-1:0] next_work;

   assign next_work = we_i ? wd_i : work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q   <= '0;
         shadow_q <= '0;
      end else begin
         case (op_i)
            CK_RESTORE: begin
               work_q <= shadow_q;
            end
            CK_COMMIT: begin
               work_q   <= next_work;
               shadow_q <= next_work;
            end
            default: begin
               work_q <= next_work;
            end
         endcase
      end
   end

   assign work_o   = work_q;
   assign shadow_o = shadow_q;

endmodule

// File: rtl/srf_cell_plain.sv
module srf_cell_plain #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wd_i,
   output logic [DATA_W-1:0] work_o
);

   logic [DATA_W-1:0] work_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         work_q <= '0;
      else if (we_i)
         work_q <= wd_i;
   end

   assign work_o = work_q;

endmodule

// File: rtl/srf_read_port.sv
module srf_read_port #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 64,
   parameter int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS*DATA_W-1:0] work_flat_i,
   input  logic [ADDR_W-1:0]          addr_i,
   output logic [DATA_W-1:0]          data_o
);

   always_comb begin
      data_o = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr_i == ADDR_W'(i))
            data_o = work_flat_i[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
   import srf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_REGS   = 64,
   parameter int NUM_SHADOW = 48,
   parameter int ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd0_addr,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [ADDR_W-1:0] rd1_addr,
   output logic [DATA_W-1:0] rd1_data,
   input  logic              commit,
   input  logic              rollback
);

   localparam int NUM_RD  = 2;
   localparam int WORK_W  = NUM_REGS * DATA_W;
   localparam int SHADE_W = NUM_SHADOW * DATA_W;

   // elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("ckpt_regfile: DATA_W must be at least 1");
   end
   if (NUM_REGS < 2) begin : g_bad_depth
      $error("ckpt_regfile: NUM_REGS must be at least 2");
   end
   if (NUM_SHADOW < 1 || NUM_SHADOW > NUM_REGS) begin : g_bad_shadow
      $error("ckpt_regfile: NUM_SHADOW must lie in 1..NUM_REGS");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("ckpt_regfile: ADDR_W too narrow for NUM_REGS");
   end

   ck_op_e              ck_op;
   logic [NUM_REGS-1:0] we_vec;
   logic [WORK_W-1:0]   work_flat;
   logic [SHADE_W-1:0]  shadow_flat;

   srf_ck_arbiter u_arb (
      .commit_i   (commit),
      .rollback_i (rollback),
      .op_o       (ck_op)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign we_vec[i] = wr_en && (wr_addr == ADDR_W'(i));

      if (i < NUM_SHADOW) begin : g_backed
         srf_cell_shadowed #(
            .DATA_W (DATA_W)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_i     (we_vec[i]),
            .wd_i     (wr_data),
            .op_i     (ck_op),
            .work_o   (work_flat[i*DATA_W +: DATA_W]),
            .shadow_o (shadow_flat[i*DATA_W +: DATA_W])
         );
      end else begin : g_plain
         srf_cell_plain #(
            .DATA_W (DATA_W)
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (we_vec[i]),
            .wd_i   (wr_data),
            .work_o (work_flat[i*DATA_W +: DATA_W])
         );
      end
   end

   logic [ADDR_W-1:0] rd_addr [NUM_RD];
   logic [DATA_W-1:0] rd_data [NUM_RD];

   assign rd_addr[0] = rd0_addr;
   assign rd_addr[1] = rd1_addr;
   assign rd0_data   = rd_data[0];
   assign rd1_data   = rd_data[1];

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      srf_read_port #(
         .DATA_W   (DATA_W),
         .NUM_REGS (NUM_REGS),
         .ADDR_W   (ADDR_W)
      ) u_port (
         .work_flat_i (work_flat),
         .addr_i      (rd_addr[p]),
         .data_o      (rd_data[p])
      );
   end

endmodule

// File: rtl/ckpt_regfile_chk.sv
module ckpt_regfile_chk #(
   parameter int DATA_W     = 32,
   parameter int NUM_REGS   = 64,
   parameter int NUM_SHADOW = 48,
   parameter int ADDR_W     = $clog2(NUM_REGS)
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic [ADDR_W-1:0]            wr_addr,
   input logic [DATA_W-1:0]            wr_data,
   input logic                         commit,
   input logic                         rollback,
   input logic [NUM_REGS*DATA_W-1:0]   work_flat,
   input logic [NUM_SHADOW*DATA_W-1:0] shadow_flat
);

   localparam int SHADE_W = NUM_SHADOW * DATA_W;
   localparam logic [ADDR_W:0] SH_LIM = (ADDR_W+1)'(NUM_SHADOW);

   // inputs seen at the previous edge
   logic              p_we;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_data;
   logic              p_cm;
   logic              p_rb;
   logic              p_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_we   <= 1'b0;
         p_addr <= '0;
         p_data <= '0;
         p_cm   <= 1'b0;
         p_rb   <= 1'b0;
      end else begin
         p_we   <= wr_en;
         p_addr <= wr_addr;
         p_data <= wr_data;
         p_cm   <= commit;
         p_rb   <= rollback;
      end
   end

   assign p_low = ({1'b0, p_addr} < SH_LIM);

   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (work_flat == '0) && (shadow_flat == '0));

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (p_we && !(p_rb && p_low)) |-> work_flat[p_addr*DATA_W +: DATA_W] == p_data);

   assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !rollback && !wr_en) |=> shadow_flat == $past(work_flat[SHADE_W-1:0]));

   assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(shadow_flat));

   assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rollback |=> work_flat[SHADE_W-1:0] == $past(shadow_flat));

   if (NUM_SHADOW < NUM_REGS) begin : g_upper
      assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ((commit || rollback) && !wr_en) |=> $stable(work_flat[NUM_REGS*DATA_W-1:SHADE_W]));
   end

   assert_commit_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_cm && !p_rb && p_we && p_low) |-> shadow_flat[p_addr*DATA_W +: DATA_W] == p_data);

   assert_rollback_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rollback) |=> $stable(shadow_flat));

endmodule

bind ckpt_regfile ckpt_regfile_chk #(
   .DATA_W     (DATA_W),
   .NUM_REGS   (NUM_REGS),
   .NUM_SHADOW (NUM_SHADOW),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .commit      (commit),
   .rollback    (rollback),
   .work_flat   (work_flat),
   .shadow_flat (shadow_flat)
);

// File: tb/ckpt_regfile_bench.sv
module ckpt_regfile_bench;

   localparam int DW = 32;
   localparam int NR = 64;
   localparam int NS = 48;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd0_addr = '0;
   logic [DW-1:0] rd0_data;
   logic [AW-1:0] rd1_addr = '0;
   logic [DW-1:0] rd1_data;
   logic          commit = 1'b0;
   logic          rollback = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [DW-1:0] exp_work   [NR];
   logic [DW-1:0] exp_shadow [NS];

   always #10 clk = ~clk;

   ckpt_regfile u_ckpt_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd0_addr (rd0_addr),
      .rd0_data (rd0_data),
      .rd1_addr (rd1_addr),
      .rd1_data (rd1_data),
      .commit   (commit),
      .rollback (rollback)
   );

   function automatic logic [DW-1:0] pat(input int i, input logic [DW-1:0] salt);
      return (32'h9E37_79B9 * DW'(i + 1)) ^ salt;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // requirement-level model of one clock edge
   task automatic model_edge(input logic we, input int a, input logic [DW-1:0] d,
                             input logic cm, input logic rb);
      if (rb) begin
         for (int i = 0; i < NS; i++) exp_work[i] = exp_shadow[i];
         if (we && a >= NS) exp_work[a] = d;
      end else begin
         if (cm)
            for (int i = 0; i < NS; i++)
               exp_shadow[i] = (we && a == i) ? d : exp_work[i];
         if (we) exp_work[a] = d;
      end
   endtask

   task automatic step(input logic we, input int a, input logic [DW-1:0] d,
                       input logic cm, input logic rb);
      @(negedge clk);
      wr_en = we; wr_addr = AW'(a); wr_data = d; commit = cm; rollback = rb;
      @(posedge clk);
      model_edge(we, a, d, cm, rb);
      #1;
      wr_en = 1'b0; commit = 1'b0; rollback = 1'b0;
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < NR; i++) begin
         rd0_addr = AW'(i);
         rd1_addr = AW'(NR - 1 - i);
         #1;
         chk({tag, " port0"}, rd0_data, exp_work[i]);
         chk({tag, " port1"}, rd1_data, exp_work[NR - 1 - i]);
      end
   endtask

   initial begin
      for (int i = 0; i < NR; i++) exp_work[i] = '0;
      for (int i = 0; i < NS; i++) exp_shadow[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all registers read zero out of reset
      sweep("R1 reset");

      // R2: fill every register, check on both ports
      for (int i = 0; i < NR; i++) step(1'b1, i, pat(i, 32'h0000_1111), 1'b0, 1'b0);
      sweep("R2 fill");

      // R2: wr_en low with live address and data changes nothing
      for (int i = 0; i < NR; i += 7) step(1'b0, i, 32'hDEAD_BEEF, 1'b0, 1'b0);
      sweep("R2 no-enable");

      // R1 + R6: rollback before any commit returns 0..47 to zero, 48..63 kept
      step(1'b0, 0, '0, 1'b0, 1'b1);
      sweep("R1 R6 rollback-from-reset");

      // R3: same-cycle read returns old value, then new value after the edge
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd5; wr_data = 32'hA5A5_0005; rd0_addr = 6'd5; rd1_addr = 6'd5;
      #1;
      chk("R3 read-during-write port0", rd0_data, exp_work[5]);
      chk("R3 read-during-write port1", rd1_data, exp_work[5]);
      @(posedge clk);
      model_edge(1'b1, 5, 32'hA5A5_0005, 1'b0, 1'b0);
      #1;
      wr_en = 1'b0;
      chk("R3 after-write port0", rd0_data, 32'hA5A5_0005);
      chk("R3 after-write port1", rd1_data, 32'hA5A5_0005);

      // R4 + R7: refill, then commit together with a write to register 7
      for (int i = 0; i < NR; i++) step(1'b1, i, pat(i, 32'h2222_0000), 1'b0, 1'b0);
      step(1'b1, 7, 32'h7777_7777, 1'b1, 1'b0);
      sweep("R7 commit-with-write");
      for (int i = 0; i < NR; i++) step(1'b1, i, pat(i, 32'h3333_3333), 1'b0, 1'b0);
      sweep("R4 overwrite");
      step(1'b0, 0, '0, 1'b0, 1'b1);
      sweep("R4 R5 R6 R7 rollback");
      chk("R7 reg7 restored", exp_work[7], 32'h7777_7777);

      // R8: commit and rollback together, rollback wins
      step(1'b1, 3, 32'hC0C0_0003, 1'b0, 1'b0);
      step(1'b0, 0, '0, 1'b1, 1'b1);
      sweep("R8 both-asserted");
      step(1'b1, 3, 32'hD0D0_0003, 1'b0, 1'b0);
      step(1'b0, 0, '0, 1'b0, 1'b1);
      sweep("R8 checkpoint intact");

      // R9: writes during rollback
      step(1'b1, 10, 32'hBAD0_0010, 1'b0, 1'b1);
      step(1'b1, 50, 32'h600D_0050, 1'b0, 1'b1);
      step(1'b1, NS - 1, 32'hBAD0_002F, 1'b0, 1'b1);
      step(1'b1, NS, 32'h600D_0030, 1'b0, 1'b1);
      sweep("R9 write-during-rollback");

      // R4 + R6: a fresh commit of a third pattern, with boundary registers
      for (int i = NS - 2; i < NS + 2; i++) step(1'b1, i, pat(i, 32'h4444_4444), 1'b0, 1'b0);
      step(1'b0, 0, '0, 1'b1, 1'b0);
      for (int i = 0; i < NR; i++) step(1'b1, i, 32'hFFFF_FFFF, 1'b0, 1'b0);
      step(1'b0, 0, '0, 1'b0, 1'b1);
      sweep("R4 R5 R6 boundary");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule